// File: doc/BRIEF.md
# Window-Constrained Deadline Packet Scheduler

This block decides, once per service slot, which of a small set of packet streams sends next. Each stream has a running deadline and a fixed gap between packets. It also has a window constraint: the number of packets it may lose (the numerator x) out of each window of consecutive packets (the denominator y). The block keeps a working copy x'/y' of that constraint. When a slot is requested, the block picks one stream that has a head packet waiting. It then moves that stream's deadline on by its gap and charges one packet to its window.

After the service, the block walks through every other stream whose deadline is already behind the current time, one step per clock. A late stream with loss tolerance left gives up its head packet: a drop pulse is raised, and the stream's tolerance and window shrink. A late stream with no tolerance left keeps its packet and raises a violation pulse instead. Either way its deadline moves on by one gap. This repeats until no stream is late, and then the block is ready for the next slot. Queues, buffering and packet transmission belong to the surrounding logic. That logic sees only head-valid flags, the time, the served stream and the drop and violation pulses.

Top module: `wcs_sched`

## Requirements
- R1: A slot request accepted while idle gives, one clock later, a one-cycle `serveValid` pulse with `serveId` naming a stream whose `headValid` bit was set. If no bit was set, no pulse is given.
- R2: Among waiting streams, the one with the smallest deadline is served.
- R3: With equal deadlines, the stream with the smaller ratio x'/y' is served. The ratios are compared as x'a*y'b against x'b*y'a.
- R4: With equal deadlines and x' zero for both streams, the stream with the larger y' is served.
- R5: With equal deadlines and equal non-zero ratios, the stream with the smaller x' is served.
- R6: All other ties go to the stream whose head arrived earlier, then to the lower stream number. The arrival time is the `nowTime` value in the first cycle that `headValid` is set while no arrival time is held. It is released when that stream is served or dropped.
- R7: A served stream's deadline grows by its gap and y' drops by one. When y' would reach zero, x' and y' reload the configured x and y.
- R8: In each scan cycle, every stream other than the one just served whose deadline is below `nowTime` and whose x' is non-zero is updated: x' and y' drop by one (reloading as in R7 when y' would reach zero), the deadline grows by one gap, and a one-cycle `dropPulse` bit is raised if its head is valid.
- R9: A late stream with x' equal to zero keeps its head packet, raises a one-cycle `violPulse` bit and has its deadline grow by one gap.
- R10: `busy` is high from the clock after an accepted slot until a scan cycle finds no late stream. Slot requests while `busy` is high are ignored.
- R11: A configuration write loads the selected stream's deadline, gap, x and y, and sets x'=x and y'=y. The gap and y must be non-zero.
- R12: After reset, every stream's deadline is the largest time value, so no stream is ever late. `serveValid`, `busy`, `dropPulse` and `violPulse` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotReq | input | 1 | Request one service slot |
| nowTime | input | TW | Current time |
| headValid | input | N | Per-stream head packet present |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | IW | Stream being configured |
| cfgDeadline | input | TW | Initial deadline |
| cfgGap | input | TW | Inter-packet gap |
| cfgX | input | CW | Loss tolerance numerator |
| cfgY | input | CW | Window denominator |
| serveValid | output | 1 | One-cycle serve pulse |
| serveId | output | IW | Stream served |
| dropPulse | output | N | Per-stream head drop pulse |
| violPulse | output | N | Per-stream window violation pulse |
| busy | output | 1 | Miss scan in progress |

## Verification
The serve result comes from one register behind the slot edge, so the bench raises `slotReq` for exactly one edge and reads `serveValid` and `serveId` at the falling edge just after it. Drop and violation pulses come one or more edges later, one scan step per clock. The bench therefore collects pulses at every falling edge until `busy` reads low, and compares the totals per stream and the number of busy cycles with the counts worked out from the deadlines, gaps and tolerances. Held slot requests during a scan are checked by counting serve pulses over those cycles.

// File: rtl/wcs_pkg.sv
`timescale 1ns/1ps
package wcs_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} wcsState_t;

  typedef struct packed {
    logic doServe;
    logic doScan;
  } wcsStrobe_t;
endpackage

// File: rtl/wcs_select.sv
`timescale 1ns/1ps
module wcs_select #(
  parameter int N  = 4,
  parameter int TW = 16,
  parameter int CW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  headValid,
  input  logic [TW-1:0] deadline [N],
  input  logic [CW-1:0] curX     [N],
  input  logic [CW-1:0] curY     [N],
  input  logic [TW-1:0] stamp    [N],
  output logic          anyValid,
  output logic [IW-1:0] winId
);
  logic [N-1:0] winOk;

  // strict pairwise precedence: true when stream a goes before stream b
  function automatic logic precedes(input int a, input int b);
    logic [2*CW-1:0] crossA, crossB;
    crossA = {{CW{1'b0}}, curX[a]} * {{CW{1'b0}}, curY[b]};
    crossB = {{CW{1'b0}}, curX[b]} * {{CW{1'b0}}, curY[a]};
    if (deadline[a] != deadline[b]) return deadline[a] < deadline[b];
    if (crossA != crossB) return crossA < crossB;
    if (curX[a] == '0 && curX[b] == '0 && curY[a] != curY[b]) return curY[a] > curY[b];
    if (curX[a] != curX[b]) return curX[a] < curX[b];
    if (stamp[a] != stamp[b]) return stamp[a] < stamp[b];
    return a < b;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_cand
    always_comb begin
      winOk[i] = headValid[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && headValid[j] && !precedes(i, j)) winOk[i] = 1'b0;
      end
    end
  end

  always_comb begin
    winId = '0;
    for (int i = 0; i < N; i++) begin
      if (winOk[i]) winId = IW'(i);
    end
  end

  assign anyValid = |headValid;

  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winOk)) else $error("two winners");                       // R6
  AST_WINNER_EXISTS: assert property (@(posedge clk) disable iff (!rstN)
    anyValid |-> (winOk != '0)) else $error("no winner");               // R1
endmodule

// File: rtl/wcs_ctrl.sv
`timescale 1ns/1ps
module wcs_ctrl
  import wcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       slotReq,
  input  logic       anyLate,
  output wcsStrobe_t strobe,
  output logic       busy
);
  wcsState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (slotReq) begin
        strobe.doServe = 1'b1;
        nextState      = ST_SCAN;
      end
      ST_SCAN: begin
        if (anyLate) strobe.doScan = 1'b1;
        else         nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy = (state == ST_SCAN);

  AST_SLOT_STARTS_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && slotReq) |=> busy) else $error("slot not taken");          // R10
  AST_SCAN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && anyLate) |=> busy) else $error("scan ended early");        // R10
endmodule

// File: rtl/wcs_datapath.sv
`timescale 1ns/1ps
module wcs_datapath
  import wcs_pkg::*;
#(
  parameter int N  = 4,
  parameter int TW = 16,
  parameter int CW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  wcsStrobe_t    strobe,
  input  logic [TW-1:0] nowTime,
  input  logic [N-1:0]  headValid,
  input  logic          cfgWe,
  input  logic [IW-1:0] cfgSel,
  input  logic [TW-1:0] cfgDeadline,
  input  logic [TW-1:0] cfgGap,
  input  logic [CW-1:0] cfgX,
  input  logic [CW-1:0] cfgY,
  output logic          serveValid,
  output logic [IW-1:0] serveId,
  output logic [N-1:0]  dropPulse,
  output logic [N-1:0]  violPulse,
  output logic          anyLate
);
  logic [TW-1:0] deadline [N];
  logic [TW-1:0] gap      [N];
  logic [TW-1:0] stamp    [N];
  logic [CW-1:0] baseX    [N];
  logic [CW-1:0] baseY    [N];
  logic [CW-1:0] curX     [N];
  logic [CW-1:0] curY     [N];
  logic [N-1:0]  armed;
  logic [N-1:0]  servedMask;
  logic [N-1:0]  lateMask;
  logic          anyValid;
  logic [IW-1:0] winId;

  wcs_select #(.N(N), .TW(TW), .CW(CW)) select_i (
    .clk(clk), .rstN(rstN), .headValid(headValid),
    .deadline(deadline), .curX(curX), .curY(curY), .stamp(stamp),
    .anyValid(anyValid), .winId(winId)
  );

  always_comb begin
    for (int k = 0; k < N; k++) begin
      lateMask[k] = (deadline[k] < nowTime) && !servedMask[k];
    end
  end
  assign anyLate = |lateMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serveValid <= 1'b0;
      serveId    <= '0;
      dropPulse  <= '0;
      violPulse  <= '0;
      servedMask <= '0;
      armed      <= '0;
      for (int k = 0; k < N; k++) begin
        deadline[k] <= '1;
        gap[k]      <= TW'(1);
        stamp[k]    <= '0;
        baseX[k]    <= '0;
        baseY[k]    <= CW'(1);
        curX[k]     <= '0;
        curY[k]     <= CW'(1);
      end
    end else begin
      serveValid <= 1'b0;
      dropPulse  <= '0;
      violPulse  <= '0;
      if (strobe.doServe) begin
        serveValid <= anyValid;
        serveId    <= winId;
        servedMask <= anyValid ? (N'(1) << winId) : '0;
      end
      for (int k = 0; k < N; k++) begin
        if (!armed[k] && headValid[k]) begin
          armed[k] <= 1'b1;
          stamp[k] <= nowTime;
        end
        if (cfgWe && cfgSel == IW'(k)) begin
          deadline[k] <= cfgDeadline;
          gap[k]      <= cfgGap;
          baseX[k]    <= cfgX;
          baseY[k]    <= cfgY;
          curX[k]     <= cfgX;
          curY[k]     <= cfgY;
        end else if (strobe.doServe && anyValid && winId == IW'(k)) begin
          deadline[k] <= deadline[k] + gap[k];
          armed[k]    <= 1'b0;
          if (curY[k] == CW'(1)) begin
            curX[k] <= baseX[k];
            curY[k] <= baseY[k];
          end else begin
            curY[k] <= curY[k] - CW'(1);
          end
        end else if (strobe.doScan && lateMask[k]) begin
          deadline[k] <= deadline[k] + gap[k];
          if (curX[k] != '0) begin
            if (curY[k] == CW'(1)) begin
              curX[k] <= baseX[k];
              curY[k] <= baseY[k];
            end else begin
              curX[k] <= curX[k] - CW'(1);
              curY[k] <= curY[k] - CW'(1);
            end
            if (headValid[k]) begin
              dropPulse[k] <= 1'b1;
              armed[k]     <= 1'b0;
            end
          end else begin
            violPulse[k] <= 1'b1;
          end
        end
      end
    end
  end

  AST_SERVE_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    serveValid |-> (($past(headValid) & (N'(1) << serveId)) != '0)) else $error("served empty stream"); // R1
  AST_CFG_SANE: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |-> (cfgGap != '0 && cfgY != '0)) else $error("bad config");  // R11

  for (genvar k = 0; k < N; k++) begin : g_chk
    AST_DROP_HAS_TOL: assert property (@(posedge clk) disable iff (!rstN)
      dropPulse[k] |-> ($past(curX[k]) != '0)) else $error("drop without tolerance"); // R8
    AST_VIOL_NO_TOL: assert property (@(posedge clk) disable iff (!rstN)
      violPulse[k] |-> ($past(curX[k]) == '0)) else $error("violation with tolerance"); // R9
    AST_WINDOW_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
      curY[k] != '0) else $error("window empty");                          // R7
  end
endmodule

// File: rtl/wcs_sched.sv
`timescale 1ns/1ps
module wcs_sched
  import wcs_pkg::*;
#(
  parameter int N  = 4,
  parameter int TW = 16,
  parameter int CW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          slotReq,
  input  logic [TW-1:0] nowTime,
  input  logic [N-1:0]  headValid,
  input  logic          cfgWe,
  input  logic [IW-1:0] cfgSel,
  input  logic [TW-1:0] cfgDeadline,
  input  logic [TW-1:0] cfgGap,
  input  logic [CW-1:0] cfgX,
  input  logic [CW-1:0] cfgY,
  output logic          serveValid,
  output logic [IW-1:0] serveId,
  output logic [N-1:0]  dropPulse,
  output logic [N-1:0]  violPulse,
  output logic          busy
);
  wcsStrobe_t strobe;
  logic       anyLate;

  wcs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .slotReq(slotReq), .anyLate(anyLate),
    .strobe(strobe), .busy(busy)
  );

  wcs_datapath #(.N(N), .TW(TW), .CW(CW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nowTime(nowTime),
    .headValid(headValid), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgDeadline(cfgDeadline), .cfgGap(cfgGap), .cfgX(cfgX), .cfgY(cfgY),
    .serveValid(serveValid), .serveId(serveId), .dropPulse(dropPulse),
    .violPulse(violPulse), .anyLate(anyLate)
  );
endmodule

// File: tb/wcs_sched_tb_top.sv
`timescale 1ns/1ps
module wcs_sched_tb_top;
  localparam int N = 4, TW = 16, CW = 8, IW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          slotReq = 1'b0;
  logic [TW-1:0] nowTime = '0;
  logic [N-1:0]  headValid = '0;
  logic          cfgWe = 1'b0;
  logic [IW-1:0] cfgSel = '0;
  logic [TW-1:0] cfgDeadline = '0;
  logic [TW-1:0] cfgGap = '0;
  logic [CW-1:0] cfgX = '0;
  logic [CW-1:0] cfgY = '0;
  logic          serveValid;
  logic [IW-1:0] serveId;
  logic [N-1:0]  dropPulse;
  logic [N-1:0]  violPulse;
  logic          busy;

  int checks = 0;
  int fails  = 0;
  int gotServe, gotId, busyCnt;
  int dropCnt [N];
  int violCnt [N];

  always #2 clk = ~clk;

  wcs_sched #(.N(N), .TW(TW), .CW(CW)) dut_i (
    .clk(clk), .rstN(rstN), .slotReq(slotReq), .nowTime(nowTime),
    .headValid(headValid), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgDeadline(cfgDeadline), .cfgGap(cfgGap), .cfgX(cfgX), .cfgY(cfgY),
    .serveValid(serveValid), .serveId(serveId), .dropPulse(dropPulse),
    .violPulse(violPulse), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; slotReq = 1'b0; headValid = '0; nowTime = '0; cfgWe = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfgStream(input int s, input int dl, input int g, input int x, input int y);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = IW'(s); cfgDeadline = TW'(dl);
    cfgGap = TW'(g); cfgX = CW'(x); cfgY = CW'(y);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // one slot; serve result one edge later, scan pulses collected until idle
  task automatic runSlot();
    @(negedge clk);
    slotReq = 1'b1;
    @(negedge clk);
    slotReq = 1'b0;
    gotServe = int'(serveValid);
    gotId    = int'(serveId);
    busyCnt  = 0;
    for (int k = 0; k < N; k++) begin dropCnt[k] = 0; violCnt[k] = 0; end
    for (int t = 0; t < 200; t++) begin
      for (int k = 0; k < N; k++) begin
        dropCnt[k] += int'(dropPulse[k]);
        violCnt[k] += int'(violPulse[k]);
      end
      if (!busy) break;
      busyCnt++;
      @(negedge clk);
    end
  endtask

  task automatic expectServe(input string req, input int id);
    check(gotServe == 1 && gotId == id, req, gotServe ? gotId : -1, id);
  endtask

  task automatic testReset();
    doReset();
    check(serveValid == 1'b0, "R12 serveValid", int'(serveValid), 0);
    check(busy == 1'b0, "R12 busy", int'(busy), 0);
    check(dropPulse == '0 && violPulse == '0, "R12 pulses", int'({dropPulse, violPulse}), 0);
  endtask

  task automatic testNoHead();
    doReset();
    runSlot();
    check(gotServe == 0, "R1 no head no serve", gotServe, 0);
  endtask

  task automatic testEdf(); // R2, R7 deadline advance, R11 config load
    doReset();
    cfgStream(0, 30, 100, 1, 4);
    cfgStream(1, 10, 100, 1, 4);
    cfgStream(2, 20, 100, 1, 4);
    headValid = 4'b0111;
    repeat (2) @(negedge clk);
    runSlot(); expectServe("R2 earliest deadline", 1);
    runSlot(); expectServe("R7 served deadline moved", 2);
    runSlot(); expectServe("R11 configured deadline order", 0);
  endtask

  task automatic testRatio(); // R3
    doReset();
    cfgStream(0, 10, 100, 2, 4);
    cfgStream(1, 10, 100, 3, 5);
    cfgStream(3, 10, 100, 1, 4);
    headValid = 4'b1011;
    repeat (2) @(negedge clk);
    runSlot(); expectServe("R3 lowest ratio", 3);
    runSlot(); expectServe("R3 next lowest ratio", 0);
  endtask

  task automatic testZeroTol(); // R4
    doReset();
    cfgStream(0, 10, 100, 0, 3);
    cfgStream(2, 10, 100, 0, 7);
    headValid = 4'b0101;
    repeat (2) @(negedge clk);
    runSlot(); expectServe("R4 larger window", 2);
  endtask

  task automatic testEqualRatio(); // R5 beats arrival order
    doReset();
    cfgStream(1, 10, 100, 2, 4);
    cfgStream(3, 10, 100, 1, 2);
    headValid = 4'b0010;
    repeat (2) @(negedge clk);
    nowTime = 16'd1;
    headValid = 4'b1010;
    repeat (2) @(negedge clk);
    runSlot(); expectServe("R5 smaller numerator", 3);
  endtask

  task automatic testArrival(); // R6
    doReset();
    cfgStream(1, 10, 100, 1, 2);
    cfgStream(2, 10, 100, 1, 2);
    headValid = 4'b0100;
    repeat (2) @(negedge clk);
    nowTime = 16'd3;
    headValid = 4'b0110;
    repeat (2) @(negedge clk);
    runSlot(); expectServe("R6 earlier arrival", 2);
    doReset();
    cfgStream(1, 10, 100, 1, 2);
    cfgStream(2, 10, 100, 1, 2);
    headValid = 4'b0110;
    repeat (2) @(negedge clk);
    runSlot(); expectServe("R6 lower index", 1);
  endtask

  task automatic testReloadDrops(); // R7 reload, R8 repeated drops
    doReset();
    cfgStream(0, 0, 10, 1, 1);
    cfgStream(1, 5, 100, 1, 1);
    headValid = 4'b0001;
    repeat (2) @(negedge clk);
    runSlot(); expectServe("R7 first serve", 0);
    nowTime = 16'd25;
    headValid = 4'b0011;
    repeat (2) @(negedge clk);
    runSlot(); expectServe("R8 serve before scan", 1);
    check(dropCnt[0] == 2, "R7 R8 drops after reload", dropCnt[0], 2);
    check(violCnt[0] == 0, "R8 no violation", violCnt[0], 0);
    check(dropCnt[1] == 0, "R8 served stream skipped", dropCnt[1], 0);
  endtask

  task automatic testExhaust(); // R8, R9, R10
    doReset();
    cfgStream(0, 2, 10, 1, 4);
    cfgStream(1, 1, 100, 1, 4);
    cfgStream(2, 3, 10, 0, 3);
    nowTime = 16'd35;
    headValid = 4'b0111;
    repeat (2) @(negedge clk);
    runSlot(); expectServe("R2 serve in miss scenario", 1);
    check(dropCnt[0] == 1, "R8 one drop", dropCnt[0], 1);
    check(violCnt[0] == 3, "R9 after tolerance spent", violCnt[0], 3);
    check(violCnt[2] == 4, "R9 zero tolerance", violCnt[2], 4);
    check(dropCnt[2] == 0, "R9 packet kept", dropCnt[2], 0);
    check(busyCnt == 5, "R10 busy length", busyCnt, 5);
  endtask

  task automatic testIgnoreBusy(); // R10
    int extra;
    doReset();
    cfgStream(0, 2, 10, 1, 4);
    cfgStream(1, 1, 100, 1, 4);
    nowTime = 16'd35;
    headValid = 4'b0011;
    repeat (2) @(negedge clk);
    slotReq = 1'b1;
    @(negedge clk);
    extra = 0;
    for (int t = 0; t < 2; t++) begin
      @(negedge clk);
      extra += int'(serveValid);
    end
    slotReq = 1'b0;
    check(extra == 0, "R10 slot ignored while busy", extra, 0);
    for (int t = 0; t < 50 && busy; t++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    testReset();
    testNoHead();
    testEdf();
    testRatio();
    testZeroTol();
    testEqualRatio();
    testArrival();
    testReloadDrops();
    testExhaust();
    testIgnoreBusy();
    finishRun();
  end
endmodule